// File: doc/BRIEF.md
# Snoop Bus Hold Arbiter

This block decides who owns the processor bus in each clock. The contenders are the processor's own bus cycles, snoop write-backs queued by the cache, and three external controls: an address hold, a back-off, and a bus request from another master. The block tracks how far the current cycle has progressed. Depending on which control is active and what kind of cycle is on the bus, it lets the cycle run to its end, splits it between transfers, or aborts it and replays it later. It issues the address strobe, reports completion of core cycles and write-backs, drives the bus grant and the address-release enable, and forwards snoop invalidate requests to the cache.

The requester holds a cycle request (length, burst or single transfers, code-prefetch flag) until it sees the completion pulse. A stub from the cache lookup pulses one line per dirty snoop hit. Each such pulse queues one write-back of a fixed number of beats. All control signals are active high. When the bus is idle, a new phase is chosen in this order: an acceptable bus request first, then a queued write-back, then the core cycle.

Top module: `snoop_bus_arbiter`

## Requirements
- R1: After a clock edge with rst_n low, addr_strobe_o, bus_grant_o, req_done_o, wb_done_o and inv_req_o are 0, and addr_release_o equals addr_hold_i.
- R2: A burst request (req_burst_i=1, length N from 1 to MAX_XFERS) gives one cycle of addr_strobe_o, followed by data cycles until N acknowledged beats have been taken. req_done_o is high in the cycle of the Nth accepted xfer_ack_i. A burst whose strobe has already been issued keeps running if addr_hold_i rises.
- R3: A single-transfer request (req_burst_i=0) issues a new addr_strobe_o for each of its N transfers. After each non-final acknowledged transfer the bus spends at least one idle cycle before the next strobe.
- R4: addr_release_o is high whenever addr_hold_i is high or the bus is granted. A strobe that follows an edge where addr_hold_i was high is always a write-back (wb_sel_o=1). A split single-transfer cycle issues no strobe while addr_hold_i is high.
- R5: Each wb_req_i pulse queues one write-back, up to WB_DEPTH outstanding. A write-back is one strobe with wb_sel_o=1 followed by WB_BEATS acknowledged beats, and wb_done_o is high on the last beat. A queued write-back goes ahead of the remainder of a split core cycle, which resumes only when the queue is empty.
- R6: backoff_i sampled high during a strobe or data cycle ends that cycle at the same edge, and xfer_ack_i at that edge counts for nothing. No strobe is issued while backoff_i is high.
- R7: After backoff_i falls, queued write-backs run first. The backed-off cycle then restarts with a new strobe and all N of its transfers.
- R8: bus_req_i is accepted only when no core cycle is partly done (R9 gives the one exception). bus_grant_o rises one clock after an accepted request and falls one clock after the request is removed. No strobe is issued while the bus is granted.
- R9: For a single-transfer request with req_nc_code_i=1, bus_req_i is accepted at any idle point after an acknowledged transfer, even in the middle of the cycle. The remaining transfers continue after the grant ends.
- R10: A snoop strobe with snp_inval_i=1 makes inv_req_o high in the next cycle. A snoop strobe with snp_inval_i=0 leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Core cycle requested, held until req_done_o |
| req_len_i | input | LW | Number of transfers in the core cycle (1..MAX_XFERS) |
| req_burst_i | input | 1 | 1 = burst on one strobe, 0 = one strobe per transfer |
| req_nc_code_i | input | 1 | Non-cacheable code prefetch (single-transfer only) |
| xfer_ack_i | input | 1 | Transfer acknowledge from the system |
| addr_hold_i | input | 1 | External address hold |
| backoff_i | input | 1 | External back-off, overrides address hold |
| bus_req_i | input | 1 | Bus request from another master |
| wb_req_i | input | 1 | Pulse: one snoop write-back to queue |
| snp_strobe_i | input | 1 | Snoop lookup strobe |
| snp_inval_i | input | 1 | Snoop asks for invalidation |
| addr_strobe_o | output | 1 | Address strobe, one cycle per address phase |
| wb_sel_o | output | 1 | Current cycle is a snoop write-back |
| addr_release_o | output | 1 | Address drivers released |
| bus_grant_o | output | 1 | Bus granted to the other master |
| req_done_o | output | 1 | Last transfer of the core cycle accepted |
| wb_done_o | output | 1 | Last beat of a write-back accepted |
| inv_req_o | output | 1 | Invalidate request to the cache |

## Verification
A bursty core cycle is run with the address hold raised after its strobe. This shows whether a burst is left to finish or is wrongly split. A single-transfer cycle is run with a write-back queued mid-way under address hold, which shows whether the write-back is placed ahead of the split remainder. A back-off in the middle of a burst, with a write-back queued during it, checks two things: that the write-back goes first, and that the replay covers the full length (completion exactly four beats after the new strobe). Bus requests are applied between cycles, inside an ordinary split cycle and inside a code-prefetch cycle, which separates the normal grant rule from its exception. A long stretch of random controls, acknowledges and requests is then compared against the reference model on every clock.

// File: rtl/bha_pkg.sv
// Shared types of the snoop bus arbiter.
package bha_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_DATA  = 2'd2,
        PH_GRANT = 2'd3
    } bus_phase_t;
endpackage

// File: rtl/bha_beat_cnt.sv
// Counts accepted beats of one bus cycle and flags the last one.
// Assumes len is nonzero and stays stable between clears.
module bha_beat_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] done_q;

    // Beats taken so far; a clear wins over a beat.
    always_ff @(posedge clk) begin
        if (!rst_n)   done_q <= '0;
        else if (clr) done_q <= '0;
        else if (inc) done_q <= done_q + W'(1);
    end

    assign last = (done_q == len - W'(1));

    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (done_q < len)); // R2
endmodule

// File: rtl/bha_pend_cnt.sv
// Queue depth of snoop write-backs waiting for the bus.
// Assumes the stub never pushes into a full queue.
module bha_pend_cnt #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic any
);
    localparam int PW = $clog2(DEPTH + 1);
    logic [PW-1:0] cnt_q;

    // Net change of outstanding write-backs per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (push && !pop)  cnt_q <= cnt_q + PW'(1);
        else if (pop && !push)  cnt_q <= cnt_q - PW'(1);
    end

    assign any = (cnt_q != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == PW'(DEPTH)) |-> !(push && !pop)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/bha_inv_flag.sv
// Turns a snoop strobe with invalidation into a one-cycle cache request.
// Assumes the cache samples the request every clock.
module bha_inv_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic inval,
    output logic inv_req
);
    // Register the invalidate request.
    always_ff @(posedge clk) begin
        if (!rst_n) inv_req <= 1'b0;
        else        inv_req <= strobe && inval;
    end

    AST_INV_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && inval) |=> inv_req); // R10
    AST_INV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && inval) |=> !inv_req); // R10
endmodule

// File: rtl/snoop_bus_arbiter.sv
// Bus ownership arbiter: core cycles, snoop write-backs, address hold,
// back-off and external bus requests. Idle-phase priority is grant, then
// write-back, then core. Assumes the requester holds its request until
// req_done_o and the write-back stub respects WB_DEPTH.
module snoop_bus_arbiter
    import bha_pkg::*;
#(
    parameter int MAX_XFERS = 4,
    parameter int WB_BEATS  = 4,
    parameter int WB_DEPTH  = 2,
    localparam int LW  = $clog2(MAX_XFERS + 1),
    localparam int WBW = $clog2(WB_BEATS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [LW-1:0] req_len_i,
    input  logic          req_burst_i,
    input  logic          req_nc_code_i,
    input  logic          xfer_ack_i,
    input  logic          addr_hold_i,
    input  logic          backoff_i,
    input  logic          bus_req_i,
    input  logic          wb_req_i,
    input  logic          snp_strobe_i,
    input  logic          snp_inval_i,
    output logic          addr_strobe_o,
    output logic          wb_sel_o,
    output logic          addr_release_o,
    output logic          bus_grant_o,
    output logic          req_done_o,
    output logic          wb_done_o,
    output logic          inv_req_o
);
    bus_phase_t    ph_q, ph_d;
    logic          own_wb_q, own_wb_d;
    logic          core_act_q, core_burst_q, core_nc_q;
    logic [LW-1:0] core_len_q;
    logic          core_last, wb_last, wb_any;

    logic cyc_live, kill, beat, core_beat, wb_beat, core_fin, wb_fin;
    logic hold_ok, idle_ok, idle_grant, idle_wb, idle_core, core_new;

    // Qualify events of the current clock.
    always_comb begin
        cyc_live   = (ph_q == PH_ADDR) || (ph_q == PH_DATA);
        kill       = backoff_i && cyc_live;
        beat       = (ph_q == PH_DATA) && xfer_ack_i && !backoff_i;
        core_beat  = beat && !own_wb_q;
        wb_beat    = beat && own_wb_q;
        core_fin   = core_beat && core_last;
        wb_fin     = wb_beat && wb_last;
        hold_ok    = !core_act_q || core_nc_q;
        idle_ok    = (ph_q == PH_IDLE) && !backoff_i;
        idle_grant = idle_ok && bus_req_i && hold_ok;
        idle_wb    = idle_ok && !idle_grant && wb_any;
        idle_core  = idle_ok && !idle_grant && !wb_any && !addr_hold_i
                     && (core_act_q || req_valid_i);
        core_new   = idle_core && !core_act_q;
    end

    // Choose the next bus phase and its owner.
    always_comb begin
        ph_d     = ph_q;
        own_wb_d = own_wb_q;
        case (ph_q)
            PH_IDLE: begin
                if (idle_grant) begin
                    ph_d = PH_GRANT;
                end else if (idle_wb) begin
                    ph_d     = PH_ADDR;
                    own_wb_d = 1'b1;
                end else if (idle_core) begin
                    ph_d     = PH_ADDR;
                    own_wb_d = 1'b0;
                end
            end
            PH_ADDR:  ph_d = backoff_i ? PH_IDLE : PH_DATA;
            PH_DATA: begin
                if (backoff_i)                        ph_d = PH_IDLE;
                else if (wb_fin || core_fin)          ph_d = PH_IDLE;
                else if (core_beat && !core_burst_q)  ph_d = PH_IDLE;
            end
            PH_GRANT: if (!bus_req_i) ph_d = PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
    end

    // Phase and owner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            own_wb_q <= 1'b0;
        end else begin
            ph_q     <= ph_d;
            own_wb_q <= own_wb_d;
        end
    end

    // Record of the core cycle that owns or waits for the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_act_q   <= 1'b0;
            core_burst_q <= 1'b0;
            core_nc_q    <= 1'b0;
            core_len_q   <= LW'(1);
        end else if (core_new) begin
            core_act_q   <= 1'b1;
            core_burst_q <= req_burst_i;
            core_nc_q    <= req_nc_code_i && !req_burst_i;
            core_len_q   <= req_len_i;
        end else if (core_fin) begin
            core_act_q   <= 1'b0;
        end
    end

    bha_beat_cnt #(.W(LW)) u_core_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (core_new || (kill && !own_wb_q)),
        .inc   (core_beat),
        .len   (core_len_q),
        .last  (core_last)
    );

    bha_beat_cnt #(.W(WBW)) u_wb_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wb_fin || (kill && own_wb_q)),
        .inc   (wb_beat),
        .len   (WBW'(WB_BEATS)),
        .last  (wb_last)
    );

    bha_pend_cnt #(.DEPTH(WB_DEPTH)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wb_req_i),
        .pop   (wb_fin),
        .any   (wb_any)
    );

    bha_inv_flag u_inv (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (snp_strobe_i),
        .inval   (snp_inval_i),
        .inv_req (inv_req_o)
    );

    assign addr_strobe_o  = (ph_q == PH_ADDR);
    assign wb_sel_o       = own_wb_q;
    assign bus_grant_o    = (ph_q == PH_GRANT);
    assign addr_release_o = addr_hold_i || bus_grant_o;
    assign req_done_o     = core_fin;
    assign wb_done_o      = wb_fin;

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |-> (req_len_i != '0 && req_len_i <= LW'(MAX_XFERS))); // R2
    AST_HOLD_STROBE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe_o && $past(addr_hold_i)) |-> wb_sel_o); // R4
    AST_BACKOFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        backoff_i |=> !addr_strobe_o); // R6
    AST_GRANT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_o) |-> $past(bus_req_i)); // R8
    AST_GRANT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant_o) |-> !$past(bus_req_i)); // R8
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_done_o && wb_done_o)); // R5
endmodule

// File: tb/tb_snoop_bus_arbiter.sv
`timescale 1ns/1ps
module tb_snoop_bus_arbiter;
    localparam int MAX_XFERS = 4;
    localparam int WB_BEATS  = 4;
    localparam int WB_DEPTH  = 2;
    localparam int LW        = $clog2(MAX_XFERS + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_burst = 1'b0, req_nc = 1'b0;
    logic [LW-1:0] req_len = LW'(1);
    logic xfer_ack = 1'b0, addr_hold = 1'b0, backoff = 1'b0, bus_req = 1'b0;
    logic wb_req = 1'b0, snp_strobe = 1'b0, snp_inval = 1'b0;
    logic addr_strobe, wb_sel, addr_release, bus_grant, req_done, wb_done, inv_req;

    always #2.5 clk = ~clk;

    snoop_bus_arbiter #(.MAX_XFERS(MAX_XFERS), .WB_BEATS(WB_BEATS), .WB_DEPTH(WB_DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_len_i(req_len),
        .req_burst_i(req_burst), .req_nc_code_i(req_nc), .xfer_ack_i(xfer_ack),
        .addr_hold_i(addr_hold), .backoff_i(backoff), .bus_req_i(bus_req),
        .wb_req_i(wb_req), .snp_strobe_i(snp_strobe), .snp_inval_i(snp_inval),
        .addr_strobe_o(addr_strobe), .wb_sel_o(wb_sel), .addr_release_o(addr_release),
        .bus_grant_o(bus_grant), .req_done_o(req_done), .wb_done_o(wb_done),
        .inv_req_o(inv_req)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;

    // Reference model state: 0 idle, 1 address, 2 data, 3 granted.
    int m_st = 0, m_own = 0, m_act = 0, m_burst = 0, m_nc = 0, m_len = 0;
    int m_cdone = 0, m_wdone = 0, m_pend = 0, m_inv = 0;

    bit saw_done = 1'b0;
    bit seq[$];
    int ads_in_boff = 0, last_core_ads = 0, done_cyc = 0, n_done = 0, n_wbdone = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Advance the model by one clock edge using the inputs seen at that edge.
    task automatic model_step();
        int kill, bt, cb, wbb, cfin, wfin, hok, nst, nown, cnew;
        if (!rst_n) begin
            m_st = 0; m_own = 0; m_act = 0; m_burst = 0; m_nc = 0; m_len = 1;
            m_cdone = 0; m_wdone = 0; m_pend = 0; m_inv = 0;
            return;
        end
        kill = backoff && (m_st == 1 || m_st == 2);
        bt   = (m_st == 2) && xfer_ack && !backoff;
        cb   = bt && !m_own;
        wbb  = bt && m_own;
        cfin = cb && (m_cdone == m_len - 1);
        wfin = wbb && (m_wdone == WB_BEATS - 1);
        hok  = !m_act || m_nc;
        nst = m_st; nown = m_own; cnew = 0;
        if (m_st == 0) begin
            if (!backoff) begin
                if (bus_req && hok) nst = 3;
                else if (m_pend > 0) begin nst = 1; nown = 1; end
                else if ((m_act || req_valid) && !addr_hold) begin
                    nst = 1; nown = 0; cnew = !m_act;
                end
            end
        end else if (m_st == 1) nst = backoff ? 0 : 2;
        else if (m_st == 2) begin
            if (backoff || wfin || cfin || (cb && !m_burst)) nst = 0;
        end else if (!bus_req) nst = 0;
        if (cnew) begin
            m_act = 1; m_burst = req_burst; m_nc = req_nc && !req_burst; m_len = req_len;
            m_cdone = 0;
        end else begin
            if (cfin) m_act = 0;
            if (kill && !m_own) m_cdone = 0;
            else if (cb) m_cdone++;
        end
        if (wfin || (kill && m_own)) m_wdone = 0;
        else if (wbb) m_wdone++;
        m_pend = m_pend + int'(wb_req) - wfin;
        m_inv  = snp_strobe && snp_inval;
        m_st = nst; m_own = nown;
    endtask

    // Compare every output against the model in the middle of the cycle.
    task automatic compare();
        int e_ads, e_grant;
        e_ads   = (m_st == 1);
        e_grant = (m_st == 3);
        chk("R3", "address strobe", addr_strobe, e_ads);
        if (e_ads) chk("R5", "write-back select", wb_sel, m_own);
        chk("R8", "bus grant", bus_grant, e_grant);
        chk("R4", "address release", addr_release, addr_hold || e_grant);
        chk("R2", "core done", req_done,
            (m_st == 2) && xfer_ack && !backoff && !m_own && (m_cdone == m_len - 1));
        chk("R5", "write-back done", wb_done,
            (m_st == 2) && xfer_ack && !backoff && m_own && (m_wdone == WB_BEATS - 1));
        chk("R10", "invalidate request", inv_req, m_inv);
        if (addr_strobe) begin
            seq.push_back(wb_sel);
            if (!wb_sel) last_core_ads = cyc;
            if (backoff) ads_in_boff++;
        end
        if (req_done) begin n_done++; done_cyc = cyc; saw_done = 1'b1; end
        if (wb_done) n_wbdone++;
        cyc++;
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        @(posedge clk);
        model_step();
        #1;
        if (saw_done) begin req_valid = 1'b0; saw_done = 1'b0; end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic issue(input int len, input bit burst, input bit nc);
        req_valid = 1'b1; req_len = LW'(len); req_burst = burst; req_nc = nc;
    endtask

    task automatic clear_log();
        seq.delete(); ads_in_boff = 0; n_done = 0; n_wbdone = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(50000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        model_step();
        #1;
        chk("R1", "strobe in reset", addr_strobe, 0);
        chk("R1", "grant in reset", bus_grant, 0);
        chk("R1", "done in reset", req_done, 0);
        chk("R1", "wb done in reset", wb_done, 0);
        chk("R1", "inv in reset", inv_req, 0);
        chk("R1", "release in reset", addr_release, 0);
        rst_n = 1'b1;
        run(2);

        // R2: burst keeps running when address hold rises after its strobe
        clear_log();
        issue(4, 1'b1, 1'b0); xfer_ack = 1'b1;
        tick();
        addr_hold = 1'b1;
        run(8);
        addr_hold = 1'b0;
        chk("R2", "burst strobes", seq.size(), 1);
        chk("R2", "burst completions", n_done, 1);
        chk("R2", "beats after strobe", done_cyc - last_core_ads, 4);

        // R3: single transfers each take their own strobe
        clear_log();
        issue(3, 1'b0, 1'b0);
        run(15);
        chk("R3", "single-transfer strobes", seq.size(), 3);
        chk("R3", "single-transfer completions", n_done, 1);

        // R4 R5: write-back placed ahead of a split cycle under address hold
        clear_log();
        issue(3, 1'b0, 1'b0); wb_req = 1'b1;
        tick();
        wb_req = 1'b0;
        run(2);
        addr_hold = 1'b1;
        run(10);
        chk("R4", "release under hold", addr_release, 1);
        chk("R4", "strobes under hold", seq.size(), 2);
        addr_hold = 1'b0;
        run(15);
        chk("R5", "strobe count", seq.size(), 4);
        if (seq.size() == 4) begin
            chk("R5", "order 0 core", seq[0], 0);
            chk("R5", "order 1 write-back", seq[1], 1);
            chk("R5", "order 2 core", seq[2], 0);
            chk("R5", "order 3 core", seq[3], 0);
        end
        chk("R5", "write-backs done", n_wbdone, 1);
        chk("R5", "core done", n_done, 1);

        // R6 R7: back-off during a burst with a write-back queued meanwhile
        clear_log();
        issue(4, 1'b1, 1'b0);
        run(3);
        backoff = 1'b1; wb_req = 1'b1;
        tick();
        wb_req = 1'b0;
        chk("R6", "strobe after back-off", addr_strobe, 0);
        chk("R6", "done during back-off", n_done, 0);
        run(2);
        backoff = 1'b0;
        run(20);
        chk("R6", "strobes while backed off", ads_in_boff, 0);
        chk("R7", "strobe count", seq.size(), 3);
        if (seq.size() == 3) begin
            chk("R7", "write-back first", seq[1], 1);
            chk("R7", "core replayed", seq[2], 0);
        end
        chk("R7", "full replay length", done_cyc - last_core_ads, 4);
        chk("R7", "core done once", n_done, 1);

        // R8: grant between cycles, not inside an ordinary split cycle
        clear_log();
        bus_req = 1'b1;
        tick();
        chk("R8", "grant one clock after request", bus_grant, 1);
        tick();
        chk("R8", "grant held", bus_grant, 1);
        bus_req = 1'b0;
        tick();
        chk("R8", "grant drop one clock after release", bus_grant, 0);
        issue(2, 1'b0, 1'b0);
        run(3);
        bus_req = 1'b1;
        run(3);
        chk("R8", "no grant mid-cycle", bus_grant, 0);
        chk("R8", "cycle finished first", n_done, 1);
        tick();
        chk("R8", "grant after cycle end", bus_grant, 1);
        bus_req = 1'b0;
        tick();

        // R9: code prefetch lets the grant in after an acknowledged transfer
        clear_log();
        issue(2, 1'b0, 1'b1);
        run(3);
        bus_req = 1'b1;
        tick();
        chk("R9", "grant inside prefetch", bus_grant, 1);
        chk("R9", "prefetch still open", n_done, 0);
        run(3);
        chk("R8", "no strobe while granted", seq.size(), 1);
        bus_req = 1'b0;
        run(8);
        chk("R9", "prefetch finished after grant", n_done, 1);

        // R10: invalidate request follows the snoop strobe
        snp_strobe = 1'b1; snp_inval = 1'b1;
        tick();
        chk("R10", "invalidate raised", inv_req, 1);
        snp_inval = 1'b0;
        tick();
        chk("R10", "no invalidate without request", inv_req, 0);
        snp_strobe = 1'b0;
        tick();

        // Random stretch, compared every clock against the model
        for (int i = 0; i < 3000; i++) begin
            xfer_ack = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 5) == 0) addr_hold = ~addr_hold;
            if (backoff) backoff = ($urandom_range(0, 2) != 0);
            else         backoff = ($urandom_range(0, 30) == 0);
            if (bus_req) bus_req = ($urandom_range(0, 5) != 0);
            else         bus_req = ($urandom_range(0, 40) == 0);
            wb_req = (m_pend < WB_DEPTH) && ($urandom_range(0, 15) == 0);
            snp_strobe = $urandom_range(0, 1);
            snp_inval  = $urandom_range(0, 1);
            if (!req_valid && $urandom_range(0, 3) == 0)
                issue($urandom_range(1, MAX_XFERS), $urandom_range(0, 1), $urandom_range(0, 1));
            tick();
        end
        addr_hold = 1'b0; backoff = 1'b0; bus_req = 1'b0; wb_req = 1'b0;
        snp_strobe = 1'b0; xfer_ack = 1'b1;
        run(60);
        chk("R5", "queue drained", m_pend, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule